// File: doc/BRIEF.md
# Opcode Remap Table and Execute Controller

This block sits between a host pipeline's instruction decoder and a set of custom compute units. It holds a writable table, indexed by a 6-bit operation opcode, whose entries name the address of the compute unit that implements the operation. Because the table can be rewritten at any time, one opcode can be bound to different units in different parts of a program. The table is written either by one combined map strobe (opcode and address together) or in two steps. In the two-step form, an opcode strobe reserves an entry, and a later address strobe fills in that reserved entry.

On an execute strobe the controller looks up the entry, pulses a start toward the addressed unit, and takes the operation latency from the unit's wrapper. It then counts that latency down. A blocking execute holds the host with a stall until the operation finishes. A concurrent execute lets the host run on. The host is held only if it asks for results, or issues another execute, before the running operation finishes.

All pins are plain control and data. The only back-pressure is `stall`. While `stall` is high in a cycle, the host keeps the same strobe and operands on the next cycle. An instruction is taken in the first cycle in which its strobe is high and `stall` is low. The exception is an execute's start cycle: the start is issued there even when `stall` is high. The host asserts at most one strobe per cycle.

Top module: `opmap_exec_ctrl`

## Requirements
- R1: After reset every table entry is invalid, and `stall`, `unit_start`, `done` and `err` are low.
- R2: A `map_wr` strobe writes `addr_in` into the entry selected by `opc_in` and marks the entry valid. A later execute of that opcode drives that address on `unit_addr`.
- R3: An `opc_wr` strobe marks the entry at `opc_in` invalid and reserves that index. The next `addr_wr` writes `addr_in` into the reserved entry, marks it valid and ends the reservation. `opc_in` is ignored during `addr_wr`.
- R4: An `addr_wr` strobe with no reservation pending changes no entry.
- R5: Rewriting an entry makes later executes of that opcode target the new address.
- R6: An execute on an invalid entry raises `err` in that cycle, leaves `unit_start` low and starts no count.
- R7: An accepted execute on a valid entry raises `unit_start` for one cycle, with `unit_addr` equal to the entry's address. A latency (`lat_in`) of 0 or 1 gives `done` in that same cycle with no stall.
- R8: A blocking execute with latency L of 2 or more raises `stall` for L-1 cycles, starting in its start cycle. `done` is high in the L-th cycle, with `stall` low.
- R9: A concurrent execute never stalls in its start cycle. With latency L of 2 or more, `done` rises L-1 cycles after the start.
- R10: A `rd_res` strobe while a concurrent operation is running stalls until the final cycle of that operation. A `rd_res` strobe with nothing running does not stall.
- R11: An execute issued while a concurrent operation runs stalls, with no start, through the final cycle of that operation. It starts in the following cycle.
- R12: Table writes while a concurrent operation runs do not stall and do not change its completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_wr | input | 1 | One-step table write strobe |
| opc_wr | input | 1 | Two-step write, first part: reserve the index |
| addr_wr | input | 1 | Two-step write, second part: fill the reserved entry |
| exec_blk | input | 1 | Blocking execute strobe |
| exec_conc | input | 1 | Concurrent execute strobe |
| rd_res | input | 1 | Result-read strobe |
| opc_in | input | OPC_W (6) | Opcode operand |
| addr_in | input | ADDR_W (8) | Unit address operand |
| lat_in | input | LAT_W (8) | Latency from the wrapper of the unit on `unit_addr` |
| unit_addr | output | ADDR_W (8) | Address looked up for `opc_in` |
| unit_start | output | 1 | Start pulse to the addressed unit |
| done | output | 1 | The operation completes this cycle |
| stall | output | 1 | Hold the host this cycle |
| err | output | 1 | Execute on an invalid entry |

## Verification
A table of opcode and address pairs is bound and then executed in blocking form. The addresses are chosen so that the unit latencies are 0, 1, 2, 3 and 5. This separates the no-stall path from the counted path and checks that the stall length follows the latency. Directed sequences then test the two-step write against a reservation, a stray address write, and a rebinding. Concurrent runs are overlapped with a result read, a second execute and table writes. These show whether the hold ends on the final cycle and whether the queued start happens exactly one cycle after it.

// File: rtl/opmap_pkg.sv
package opmap_pkg;
  localparam int OPC_W_DEF  = 6;
  localparam int ADDR_W_DEF = 8;
  localparam int LAT_W_DEF  = 8;

  typedef enum logic {
    RUN_CONC = 1'b0,
    RUN_BLK  = 1'b1
  } run_mode_e;
endpackage

// File: rtl/opmap_table.sv
module opmap_table #(
  parameter int OPC_W  = opmap_pkg::OPC_W_DEF,
  parameter int ADDR_W = opmap_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr,
  input  logic              opc_wr,
  input  logic              addr_wr,
  input  logic [OPC_W-1:0]  opc_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_vld,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int DEPTH = 1 << OPC_W;

  logic              resv_q;
  logic [OPC_W-1:0]  resv_idx_q;
  logic              set_en;
  logic [OPC_W-1:0]  set_idx;
  logic [DEPTH-1:0]  vld_vec;
  logic [ADDR_W-1:0] addr_vec [DEPTH];

  // the one-step write and the fill of a reserved index share one write port
  always_comb begin
    set_en  = map_wr | (addr_wr & resv_q);
    set_idx = map_wr ? opc_in : resv_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_q     <= 1'b0;
      resv_idx_q <= '0;
    end else if (opc_wr) begin
      resv_q     <= 1'b1;
      resv_idx_q <= opc_in;
    end else if (addr_wr) begin
      resv_q     <= 1'b0;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              v_q;
    logic [ADDR_W-1:0] a_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                v_q <= 1'b0;
      else if (set_en && set_idx == OPC_W'(i))   v_q <= 1'b1;
      else if (opc_wr && opc_in == OPC_W'(i))    v_q <= 1'b0;
    end
    always_ff @(posedge clk) begin
      if (set_en && set_idx == OPC_W'(i)) a_q <= addr_in;
    end
    assign vld_vec[i]  = v_q;
    assign addr_vec[i] = a_q;
  end

  assign rd_vld  = vld_vec[opc_in];
  assign rd_addr = addr_vec[opc_in];

  assert_map_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> vld_vec[$past(opc_in)]);
  assert_reserve_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    opc_wr |=> resv_q);
  assert_fill_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !opc_wr) |=> !resv_q);
  assert_stray_fill_inert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !resv_q && !map_wr && !opc_wr) |=> (vld_vec == $past(vld_vec)));
endmodule

// File: rtl/opmap_lat_counter.sv
module opmap_lat_counter #(
  parameter int LAT_W = opmap_pkg::LAT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (busy)   cnt_q <= cnt_q - LAT_W'(1);
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == LAT_W'(1));

  assert_count_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last && !load) |=> !busy);
  assert_load_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
  assert_load_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);
endmodule

// File: rtl/opmap_exec_ctrl.sv
module opmap_exec_ctrl #(
  parameter int OPC_W  = opmap_pkg::OPC_W_DEF,
  parameter int ADDR_W = opmap_pkg::ADDR_W_DEF,
  parameter int LAT_W  = opmap_pkg::LAT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr,
  input  logic              opc_wr,
  input  logic              addr_wr,
  input  logic              exec_blk,
  input  logic              exec_conc,
  input  logic              rd_res,
  input  logic [OPC_W-1:0]  opc_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LAT_W-1:0]  lat_in,
  output logic [ADDR_W-1:0] unit_addr,
  output logic              unit_start,
  output logic              done,
  output logic              stall,
  output logic              err
);
  import opmap_pkg::*;

  logic            hit;
  logic            busy, last;
  logic            exec_any, accept, multi, load;
  logic [LAT_W-1:0] load_val;
  run_mode_e       mode_q;

  opmap_table #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .map_wr(map_wr), .opc_wr(opc_wr), .addr_wr(addr_wr),
    .opc_in(opc_in), .addr_in(addr_in),
    .rd_vld(hit), .rd_addr(unit_addr)
  );

  opmap_lat_counter #(.LAT_W(LAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_val(load_val),
    .busy(busy), .last(last)
  );

  always_comb begin
    exec_any   = exec_blk | exec_conc;
    accept     = exec_any & ~busy;
    unit_start = accept & hit;
    err        = accept & ~hit;
    multi      = (lat_in > LAT_W'(1));
    load       = unit_start & multi;
    load_val   = lat_in - LAT_W'(1);
    done       = (unit_start & ~multi) | (busy & last);
    // a blocking run freezes the host, so a strobe seen then is the held one
    stall = (unit_start & multi & exec_blk)
          | (busy & (mode_q == RUN_BLK) & ~last)
          | (busy & (mode_q == RUN_CONC) & exec_any)
          | (busy & (mode_q == RUN_CONC) & rd_res & ~last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= RUN_CONC;
    else if (load) mode_q <= exec_blk ? RUN_BLK : RUN_CONC;
  end

  assert_blk_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == RUN_BLK && !last) |-> stall);
  assert_conc_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_conc && !busy) |-> !stall);
  assert_read_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == RUN_CONC && rd_res && !last) |-> stall);
  assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !unit_start);
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_start && multi) |=> !unit_start);
endmodule

// File: tb/sim_opmap_exec_ctrl.sv
module sim_opmap_exec_ctrl;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  // {opcode, address}; the model wrapper latency is address[3:0]
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  8'h11}, {6'd63, 8'hA0}, {6'd5,  8'h32},
    {6'd17, 8'h45}, {6'd40, 8'hF1}, {6'd9,  8'h03}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic map_wr = 0, opc_wr = 0, addr_wr = 0, exec_blk = 0, exec_conc = 0, rd_res = 0;
  logic [5:0] opc_in = '0;
  logic [7:0] addr_in = '0, lat_in, unit_addr;
  logic unit_start, done, stall, err;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;
  assign lat_in = {4'b0, unit_addr[3:0]};

  opmap_exec_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .map_wr(map_wr), .opc_wr(opc_wr), .addr_wr(addr_wr),
    .exec_blk(exec_blk), .exec_conc(exec_conc), .rd_res(rd_res),
    .opc_in(opc_in), .addr_in(addr_in), .lat_in(lat_in),
    .unit_addr(unit_addr), .unit_start(unit_start), .done(done), .stall(stall), .err(err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    map_wr = 0; opc_wr = 0; addr_wr = 0; exec_blk = 0; exec_conc = 0; rd_res = 0;
  endtask

  task automatic wr_map(logic [5:0] o, logic [7:0] a);
    map_wr = 1; opc_in = o; addr_in = a; nxt(); idle();
  endtask

  task automatic run_blk(logic [5:0] o, int exp_addr, string tag);
    int lat, n;
    lat = (exp_addr % 16 < 1) ? 1 : exp_addr % 16;
    exec_blk = 1; opc_in = o; #1;
    chk({tag, " start"}, unit_start, 1);
    chk({tag, " addr"}, unit_addr, exp_addr);
    n = 0;
    while (stall && n < 40) begin nxt(); #1; n++; end
    chk({tag, " stall cycles"}, n, lat - 1);
    chk({tag, " done"}, done, 1);
    nxt(); idle();
  endtask

  task automatic exec_err(logic [5:0] o, string tag);
    exec_blk = 1; opc_in = o; #1;
    chk({tag, " err"}, err, 1);
    chk({tag, " no start"}, unit_start, 0);
    nxt(); idle();
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 stall", stall, 0); chk("R1 start", unit_start, 0);
    chk("R1 done", done, 0);   chk("R1 err", err, 0);
    @(negedge clk);
    exec_err(6'd7, "R1 empty table");

    // R2 R7 R8 vector table
    for (int i = 0; i < NV; i++) wr_map(VEC[i][13:8], VEC[i][7:0]);
    for (int i = 0; i < NV; i++) run_blk(VEC[i][13:8], VEC[i][7:0], "R2 R7 R8 vec");
    exec_err(6'd1, "R6 unmapped");

    // R5 rebind
    wr_map(6'd5, 8'h24);
    run_blk(6'd5, 8'h24, "R5 rebind");

    // R3 two-step write
    wr_map(6'd12, 8'h51);
    opc_wr = 1; opc_in = 6'd12; addr_in = 8'hEE; nxt(); idle();
    exec_err(6'd12, "R3 reserved invalid");
    addr_wr = 1; opc_in = 6'd30; addr_in = 8'h62; nxt(); idle();
    run_blk(6'd12, 8'h62, "R3 filled");
    exec_err(6'd30, "R3 opc ignored");

    // R4 stray address write
    addr_wr = 1; opc_in = 6'd12; addr_in = 8'h77; nxt(); idle();
    run_blk(6'd12, 8'h62, "R4 stray");
    exec_err(6'd31, "R4 stray other");

    // R9 concurrent with no read: latency 3
    exec_conc = 1; opc_in = 6'd9; #1;
    chk("R9 start", unit_start, 1); chk("R9 no stall", stall, 0); chk("R9 not done", done, 0);
    nxt(); idle(); #1; chk("R9 done+1", done, 0);
    nxt(); #1; chk("R9 done+2", done, 1);
    nxt();

    // R10 read while running: latency 6
    wr_map(6'd20, 8'h06);
    rd_res = 1; #1; chk("R10 idle read", stall, 0); nxt(); idle();
    exec_conc = 1; opc_in = 6'd20; #1; chk("R10 conc start", unit_start, 1);
    nxt(); idle(); rd_res = 1; #1;
    n = 0;
    while (stall && n < 40) begin nxt(); #1; n++; end
    chk("R10 read stall cycles", n, 4); chk("R10 done", done, 1);
    nxt(); idle();

    // R11 execute behind a running concurrent operation
    exec_conc = 1; opc_in = 6'd20; nxt(); idle();
    exec_blk = 1; opc_in = 6'd5; #1;
    n = 0;
    while (stall && !unit_start && n < 40) begin nxt(); #1; n++; end
    chk("R11 wait cycles", n, 5);
    chk("R11 start", unit_start, 1); chk("R11 addr", unit_addr, 8'h24);
    n = 0;
    while (stall && n < 40) begin nxt(); #1; n++; end
    chk("R11 blk stall", n, 3); chk("R11 done", done, 1);
    nxt(); idle();

    // R12 table write while running
    exec_conc = 1; opc_in = 6'd20; nxt(); idle();
    map_wr = 1; opc_in = 6'd40; addr_in = 8'h13; #1;
    chk("R12 write no stall", stall, 0);
    nxt(); idle(); rd_res = 1; #1;
    n = 0;
    while (stall && n < 40) begin nxt(); #1; n++; end
    chk("R12 read stall cycles", n, 3); chk("R12 done", done, 1);
    nxt(); idle();
    run_blk(6'd40, 8'h13, "R12 new entry");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule